// File: doc/BRIEF.md
# Bit-Banged Two-Wire Bus Port

This block is a small byte-addressed register bank through which software drives an open-drain two-wire bus (clock line and data line) by hand. One byte holds the values to drive, one byte holds per-line direction bits, and one read-only byte reports the line levels, sampled through a synchroniser a fixed number of cycles after every write that changes the drive. All bus sequencing (start, stop, bit timing, acknowledge) stays in software. The block only turns register writes into pad enables and turns line levels back into readable bits.

A write counts only when it targets the value or direction byte and carries data that differs from what is already stored. Only such a write recomputes the line drive and starts a new line sample. A write to the data line re-derives its drive from the direction bit every time, and releases the line when that bit is clear. The clock line drive only moves when its direction bit is set, and otherwise holds its last level.

Top module: `gpio_smbus_port`

## Requirements
- R1: After reset all three bytes read 0x00 and both pad enables are low, so both lines are released.
- R2: With rd_i high, rdata_o shows the addressed byte: address 0 is the sensed byte, address 1 the value byte, address 2 the direction byte. With rd_i low, rdata_o is 0x00. Bit 0 of bytes 1 and 2 belongs to the data line and bit 1 to the clock line.
- R3: A write to address 1 or 2 whose data differs from the stored byte stores it and updates the line drive on the same clock edge. A write carrying the byte already stored changes nothing and starts no line sample.
- R4: After a write that counts, the data line is driven to value bit 0 when direction bit 0 is 1, and is released when direction bit 0 is 0.
- R5: After a write that counts, the clock line takes value bit 1 only when direction bit 1 is 1. When direction bit 1 is 0, the clock drive keeps its previous level.
- R6: Each pad enable is high exactly when its line is driven to 0. A line driven to 1 is released.
- R7: SYNC_STAGES+1 clock edges after a write that counts, byte 0 captures the synchronised data level in bit 0 and the clock level in bit 1, with bits 7:2 zero. Between captures, line changes do not appear in byte 0.
- R8: A write that counts and lands on the edge of a pending capture cancels that capture and restarts the full delay.
- R9: Writes to address 0 change no byte, no line drive and start no capture.
- R10: Address 3 reads as 0x00. A write to address 3 changes no byte and no line drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Byte select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address and strobe |
| scl_i | input | 1 | Clock line level, asynchronous |
| sda_i | input | 1 | Data line level, asynchronous |
| scl_oe_o | output | 1 | Clock line pull-down enable |
| sda_oe_o | output | 1 | Data line pull-down enable |

## Verification
The line sample due from one write and a second write that counts can fall on the same clock edge. The bench provokes this by sending the second write exactly SYNC_STAGES+1 edges after the first, with the data line changed by the first write. It judges R8 by reading byte 0 on that edge and on the next one, where it must still hold the old level, and again after a full delay, where the new level must appear. A second overlap is a same-byte write while an external device pulls the data line low. Here byte 0 must stay unchanged, which shows that no sample was started.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [1:0] ADDR_IN  = 2'd0;
  localparam logic [1:0] ADDR_OUT = 2'd1;
  localparam logic [1:0] ADDR_DIR = 2'd2;
  localparam logic [1:0] ADDR_RSV = 2'd3;
  localparam int unsigned BIT_SDA = 0;
  localparam int unsigned BIT_SCL = 1;
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar w = 0; w < WIDTH; w++) begin : g_line
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[w] <= '1;
        else         chain_q[w] <= d_i[w];
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[w] <= '1;
        else         chain_q[w] <= {chain_q[w][STAGES-2:0], d_i[w]};
      end
    end
    assign q_o[w] = chain_q[w][STAGES-1];
  end
endmodule

// File: rtl/gsp_regs.sv
module gsp_regs
  import gsp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              sda_s_i,
  input  logic              scl_s_i,
  output logic              eff_o,
  output logic [BYTE_W-1:0] out_nx_o,
  output logic [BYTE_W-1:0] dir_nx_o,
  output logic [BYTE_W-1:0] dir_q_o
);
  localparam int unsigned LAT = SYNC_STAGES + 1;
  localparam int unsigned CW  = $clog2(LAT + 1);

  logic [BYTE_W-1:0] in_q, out_q, dir_q;
  logic [CW-1:0]     cnt_q;
  logic              hit_out, hit_dir, capture;

  always_comb begin
    hit_out  = wr_i && (addr_i == ADDR_OUT) && (wdata_i != out_q);
    hit_dir  = wr_i && (addr_i == ADDR_DIR) && (wdata_i != dir_q);
    eff_o    = hit_out || hit_dir;
    out_nx_o = hit_out ? wdata_i : out_q;
    dir_nx_o = hit_dir ? wdata_i : dir_q;
    capture  = !eff_o && (cnt_q == CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      in_q  <= '0;
      cnt_q <= '0;
    end else begin
      out_q <= out_nx_o;
      dir_q <= dir_nx_o;
      if (eff_o)              cnt_q <= CW'(LAT);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
      if (capture) begin
        in_q          <= '0;
        in_q[BIT_SDA] <= sda_s_i;
        in_q[BIT_SCL] <= scl_s_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_IN:  rdata_o = in_q;
        ADDR_OUT: rdata_o = out_q;
        ADDR_DIR: rdata_o = dir_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign dir_q_o = dir_q;
endmodule

// File: rtl/gsp_line_drv.sv
module gsp_line_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eff_i,
  input  logic sda_val_i,
  input  logic sda_dir_i,
  input  logic scl_val_i,
  input  logic scl_dir_i,
  output logic sda_oe_o,
  output logic scl_oe_o
);
  logic sda_lvl_q, scl_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_lvl_q <= 1'b1;
      scl_lvl_q <= 1'b1;
    end else if (eff_i) begin
      sda_lvl_q <= sda_dir_i ? sda_val_i : 1'b1;
      if (scl_dir_i) scl_lvl_q <= scl_val_i;
    end
  end

  // open drain: pull down only for a driven 0
  assign sda_oe_o = !sda_lvl_q;
  assign scl_oe_o = !scl_lvl_q;
endmodule

// File: rtl/gpio_smbus_port.sv
module gpio_smbus_port
  import gsp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic [1:0]        line_s;
  logic              eff;
  logic [BYTE_W-1:0] out_nx, dir_nx, dir_q;

  gsp_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  gsp_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .sda_s_i (line_s[0]),
    .scl_s_i (line_s[1]),
    .eff_o   (eff),
    .out_nx_o(out_nx),
    .dir_nx_o(dir_nx),
    .dir_q_o (dir_q)
  );

  gsp_line_drv u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eff_i    (eff),
    .sda_val_i(out_nx[BIT_SDA]),
    .sda_dir_i(dir_nx[BIT_SDA]),
    .scl_val_i(out_nx[BIT_SCL]),
    .scl_dir_i(dir_nx[BIT_SCL]),
    .sda_oe_o (sda_oe_o),
    .scl_oe_o (scl_oe_o)
  );
endmodule

// File: rtl/gpio_smbus_port_chk.sv
module gpio_smbus_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] rdata_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic [7:0] dir_q
);
  // R2
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);
  // R3
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sda_oe_o) && $stable(scl_oe_o));
  // R4
  sda_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_q[0] |-> !sda_oe_o);
  // R7
  in_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd0 |-> rdata_o[7:2] == 6'd0);
  // R9
  byte0_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd0 |=> $stable(sda_oe_o) && $stable(scl_oe_o));
  // R10
  byte3_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd3 |=> $stable(sda_oe_o) && $stable(scl_oe_o));
  // R10
  byte3_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd3 |-> rdata_o == 8'h00);
endmodule

bind gpio_smbus_port gpio_smbus_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .rdata_o (rdata_o),
  .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o),
  .dir_q   (dir_q)
);

// File: tb/gpio_smbus_port_bench.sv
`timescale 1ns/1ps
module gpio_smbus_port_bench;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned LAT = SYNC_STAGES + 1;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       scl_oe, sda_oe;
  logic       slave_sda_low = 1'b0, slave_scl_low = 1'b0;
  wire        sda_line = !(sda_oe || slave_sda_low);
  wire        scl_line = !(scl_oe || slave_scl_low);
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_smbus_port #(.SYNC_STAGES(SYNC_STAGES)) u_gpio_smbus_port (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
    chk("R1 scl_oe", {7'd0, scl_oe}, 8'd0);
    for (int a = 0; a < 3; a++) begin
      rd_byte(a[1:0], d);
      chk("R1 byte", d, 8'h00);
    end
    addr = 2'd0; #1;
    chk("R2 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_sda_drive();
    logic [7:0] d;
    wr_byte(2'd2, 8'h01);
    chk("R4 sda driven low", {7'd0, sda_oe}, 8'd1);
    chk("R6 scl released", {7'd0, scl_oe}, 8'd0);
    rd_byte(2'd2, d);
    chk("R2 dir byte", d, 8'h01);
    settle();
    rd_byte(2'd0, d);
    chk("R7 sensed sda low", d, 8'h02);
  endtask

  task automatic t_defer();
    logic [7:0] d;
    wr_byte(2'd1, 8'h01);
    chk("R4 sda released", {7'd0, sda_oe}, 8'd0);
    @(negedge clk);
    wr_byte(2'd1, 8'h05);
    rd_byte(2'd0, d);
    chk("R8 capture cancelled", d, 8'h02);
    @(negedge clk);
    rd_byte(2'd0, d);
    chk("R8 delay restarted", d, 8'h02);
    settle();
    rd_byte(2'd0, d);
    chk("R7 sensed sda high", d, 8'h03);
  endtask

  task automatic t_redundant();
    logic [7:0] d;
    slave_sda_low = 1'b1;
    wr_byte(2'd1, 8'h05);
    settle();
    rd_byte(2'd0, d);
    chk("R3 same byte no sample", d, 8'h03);
    wr_byte(2'd1, 8'h07);
    settle();
    rd_byte(2'd0, d);
    chk("R3 new byte samples", d, 8'h02);
    rd_byte(2'd1, d);
    chk("R3 value stored", d, 8'h07);
    slave_sda_low = 1'b0;
  endtask

  task automatic t_scl();
    wr_byte(2'd1, 8'h05);
    chk("R5 scl ignores value", {7'd0, scl_oe}, 8'd0);
    wr_byte(2'd2, 8'h03);
    chk("R5 scl driven low", {7'd0, scl_oe}, 8'd1);
    chk("R6 sda high released", {7'd0, sda_oe}, 8'd0);
    wr_byte(2'd2, 8'h01);
    chk("R5 scl holds", {7'd0, scl_oe}, 8'd1);
    wr_byte(2'd1, 8'h07);
    chk("R5 scl holds on value", {7'd0, scl_oe}, 8'd1);
    wr_byte(2'd2, 8'h03);
    chk("R5 scl released", {7'd0, scl_oe}, 8'd0);
    wr_byte(2'd1, 8'h06);
    chk("R4 sda low", {7'd0, sda_oe}, 8'd1);
    wr_byte(2'd2, 8'h02);
    chk("R4 sda released by dir", {7'd0, sda_oe}, 8'd0);
    settle();
  endtask

  task automatic t_byte0();
    logic [7:0] pre, d;
    rd_byte(2'd0, pre);
    chk("R7 byte0 after scl test", pre, 8'h03);
    slave_sda_low = 1'b1;
    wr_byte(2'd0, 8'hFC);
    chk("R9 sda_oe", {7'd0, sda_oe}, 8'd0);
    settle();
    rd_byte(2'd0, d);
    chk("R9 byte0 unchanged", d, pre);
    slave_sda_low = 1'b0;
  endtask

  task automatic t_byte3();
    logic [7:0] d;
    wr_byte(2'd3, 8'hA5);
    chk("R10 sda_oe", {7'd0, sda_oe}, 8'd0);
    chk("R10 scl_oe", {7'd0, scl_oe}, 8'd0);
    rd_byte(2'd3, d);
    chk("R10 read zero", d, 8'h00);
    rd_byte(2'd1, d);
    chk("R10 value byte kept", d, 8'h06);
    rd_byte(2'd2, d);
    chk("R10 dir byte kept", d, 8'h02);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_sda_drive();
    t_defer();
    t_redundant();
    t_scl();
    t_byte0();
    t_byte3();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule